// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Converter

This block turns a parallel word into a one-bit NRZ stream, one bit for each period of a fast clock. It contains its own phase counter, which sets when a word is taken in and also supplies two divided clocks. One runs at the word rate, the other at twice the word period. A system uses these clocks to present the next parallel word in time. With the default width of four, they are the divide-by-4 and divide-by-8 clocks.

A mode input chooses the frame length. In single mode, each load sends one word. In cascade mode, each load starts an eight-bit frame. The block first sends its own four bits. It then forwards four bits that arrive on a serial input, so a second converter can feed its stream through this one. An asynchronous sync input clears the phase counter and pins the divided clocks low. The user can then place the start of a word on a chosen clock. A synchronous active-high reset brings every register to zero.

The serial output register is clocked on the falling edge. All other state changes on the rising edge.

Top module: `p2s_converter`

## Requirements
- R1: With `mode`=0, each word leaves on `sout` as `din[0]`, `din[1]`, `din[2]`, `din[3]` on four consecutive falling edges.
- R2: With `mode`=0, a new word is loaded every fourth rising edge. Consecutive words leave with no gap bit between them.
- R3: With `mode`=1, each load produces an eight-bit frame. The first four bits are `din[0]` to `din[3]`. The last four bits are the values of `ser_in` sampled at the 5th, 6th, 7th and 8th rising edges of the frame. The next load occurs eight rising edges after the previous one.
- R4: Counting rising edges n=1,2,… after sync is released, `clk_div_word` equals bit 1 of n and `clk_div_frame` equals bit 2 of n. This gives square waves with a 50% duty cycle and periods of 4 and 8 clocks.
- R5: While `sync` is 1, both divided clocks are 0 regardless of the clock. The first rising edge after release loads `din`, and `din[0]` appears on `sout` at the falling edge that follows.
- R6: While `sync` is 1, `sout` keeps its last value.
- R7: `din` is sampled only on a load edge, and later changes do not alter the word in flight. `ser_in` has no effect in mode 0, and no effect during the first four bits of a cascade frame.
- R8: `sout` changes only at falling edges of `clk`, and is unchanged across rising edges.
- R9: A synchronous `rst`=1 drives `sout`, `clk_div_word` and `clk_div_frame` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Asynchronous phase-counter clear, active high |
| mode | input | 1 | 0 = single word frame, 1 = cascade double frame |
| din | input | WORD_W | Parallel word, bit 0 sent first |
| ser_in | input | 1 | Serial stream from an upstream converter |
| sout | output | 1 | Serial NRZ output, updated on falling edges |
| clk_div_word | output | 1 | Clock divided by WORD_W |
| clk_div_frame | output | 1 | Clock divided by 2*WORD_W |

## Verification
Several word patterns are sent in both modes.
- Alternating bits (0xA, 0x5) expose any error in bit order or an off-by-one shift.
- The patterns 0x1 and 0xE mark a single end bit, so the LSB-first order is confirmed.
- All-zero own bits followed by all-one serial bits show where cascade mode switches from its own word to `ser_in`.
- While the serial input is not used, it is driven to the complement of the expected bit, so any leak from it shows up as a wrong bit.
- Back-to-back words in each mode confirm the load spacing.
- A sync pulse in the middle of a frame confirms the output hold, the low divided clocks and the realigned restart.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

    localparam int unsigned DEF_WORD_W = 4;

    typedef enum logic {
        CONV_SINGLE  = 1'b0,
        CONV_CASCADE = 1'b1
    } conv_mode_e;

    // Number of serial bits emitted per load in the given mode.
    function automatic int unsigned frame_len(conv_mode_e m, int unsigned w);
        return (m == CONV_CASCADE) ? 2 * w : w;
    endfunction

endpackage

// File: rtl/p2s_divider.sv
// Phase counter: cleared asynchronously by sync, synchronously by rst.
// Its upper bits are the divided clocks.
module p2s_divider #(
    parameter int unsigned WORD_W = p2s_pkg::DEF_WORD_W,
    localparam int unsigned PH_W  = $clog2(2 * WORD_W),
    localparam int unsigned SUB_W = $clog2(WORD_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync,
    output logic [PH_W-1:0] phase,
    output logic            clk_div_word,
    output logic            clk_div_frame
);

    always_ff @(posedge clk or posedge sync) begin
        if (sync) begin
            phase <= '0;
        end else if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    assign clk_div_word  = phase[SUB_W-1];
    assign clk_div_frame = phase[PH_W-1];

endmodule

// File: rtl/p2s_shifter.sv
// Load and shift path: picks the next bit to send on each rising edge.
module p2s_shifter #(
    parameter int unsigned WORD_W = p2s_pkg::DEF_WORD_W,
    localparam int unsigned PH_W  = $clog2(2 * WORD_W),
    localparam int unsigned SUB_W = $clog2(WORD_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync,
    input  p2s_pkg::conv_mode_e  mode,
    input  logic [PH_W-1:0]      phase,
    input  logic [WORD_W-1:0]    din,
    input  logic                 ser_in,
    output logic                 bit_q
);
    import p2s_pkg::*;

    logic [WORD_W-1:0] sh;
    logic [SUB_W-1:0]  sub_pos;
    logic              upper_half;
    logic              load;
    logic              from_chain;

    assign sub_pos    = phase[SUB_W-1:0];
    assign upper_half = phase[PH_W-1];

    always_comb begin
        load       = (sub_pos == '0) && ((mode == CONV_SINGLE) || !upper_half);
        from_chain = (mode == CONV_CASCADE) && upper_half;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            bit_q <= 1'b0;
        end else if (!sync) begin
            if (load) begin
                sh    <= din >> 1;
                bit_q <= din[0];
            end else begin
                sh    <= sh >> 1;
                bit_q <= from_chain ? ser_in : sh[0];
            end
        end
    end

endmodule

// File: rtl/p2s_out_stage.sv
// Falling-edge serial output register; frozen while sync is held.
module p2s_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic sync,
    input  logic bit_q,
    output logic sout
);

    always_ff @(negedge clk) begin
        if (rst) begin
            sout <= 1'b0;
        end else if (!sync) begin
            sout <= bit_q;
        end
    end

endmodule

// File: rtl/p2s_converter.sv
module p2s_converter #(
    parameter int unsigned WORD_W = p2s_pkg::DEF_WORD_W,
    localparam int unsigned PH_W  = $clog2(2 * WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync,
    input  logic              mode,
    input  logic [WORD_W-1:0] din,
    input  logic              ser_in,
    output logic              sout,
    output logic              clk_div_word,
    output logic              clk_div_frame
);
    import p2s_pkg::*;

    logic [PH_W-1:0] phase;
    logic            bit_q;
    conv_mode_e      mode_e;

    assign mode_e = conv_mode_e'(mode);

    p2s_divider #(.WORD_W(WORD_W)) u_div (
        .clk           (clk),
        .rst           (rst),
        .sync          (sync),
        .phase         (phase),
        .clk_div_word  (clk_div_word),
        .clk_div_frame (clk_div_frame)
    );

    p2s_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .sync   (sync),
        .mode   (mode_e),
        .phase  (phase),
        .din    (din),
        .ser_in (ser_in),
        .bit_q  (bit_q)
    );

    p2s_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .sync  (sync),
        .bit_q (bit_q),
        .sout  (sout)
    );

endmodule

// File: rtl/p2s_converter_chk.sv
module p2s_converter_chk #(
    parameter int unsigned WORD_W = p2s_pkg::DEF_WORD_W,
    localparam int unsigned GW    = $clog2(2 * WORD_W) + 1
) (
    input logic clk,
    input logic rst,
    input logic sync,
    input logic sout,
    input logic clk_div_word,
    input logic clk_div_frame
);

    logic          dw_q, df_q, arm_w, arm_f;
    logic [GW-1:0] gap_w, gap_f;

    // Edge-to-edge spacing of the divided clocks, measured in rising edges.
    always_ff @(posedge clk) begin
        if (rst || sync) begin
            dw_q  <= 1'b0;
            df_q  <= 1'b0;
            arm_w <= 1'b0;
            arm_f <= 1'b0;
            gap_w <= '0;
            gap_f <= '0;
        end else begin
            dw_q <= clk_div_word;
            df_q <= clk_div_frame;
            if (clk_div_word && !dw_q) begin
                gap_w <= '0;
                arm_w <= 1'b1;
            end else begin
                gap_w <= gap_w + GW'(1);
            end
            if (clk_div_frame && !df_q) begin
                gap_f <= '0;
                arm_f <= 1'b1;
            end else begin
                gap_f <= gap_f + GW'(1);
            end
        end
    end

    AST_DIV_WORD_PERIOD: assert property (@(posedge clk) disable iff (rst || sync)
        (clk_div_word && !dw_q && arm_w) |-> (gap_w == GW'(WORD_W - 1))); // R4

    AST_DIV_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst || sync)
        (clk_div_frame && !df_q && arm_f) |-> (gap_f == GW'(2 * WORD_W - 1))); // R4

    AST_FRAME_TOGGLES_ON_WORD_FALL: assert property (@(posedge clk) disable iff (rst || sync)
        $fell(clk_div_word) |-> (clk_div_frame != $past(clk_div_frame))); // R4

    AST_DIV_LOW_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        sync |-> (!clk_div_word && !clk_div_frame)); // R5

    AST_SOUT_HOLD_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sync && $past(sync)) |-> $stable(sout)); // R6

endmodule

bind p2s_converter p2s_converter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sync          (sync),
    .sout          (sout),
    .clk_div_word  (clk_div_word),
    .clk_div_frame (clk_div_frame)
);

// File: tb/p2s_converter_tb.sv
`timescale 1ns/1ps
module p2s_converter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] din = '0;
    logic         ser_in = 1'b0;
    logic         sout, clk_div_word, clk_div_frame;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    p2s_converter #(.WORD_W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .sync          (sync),
        .mode          (mode),
        .din           (din),
        .ser_in        (ser_in),
        .sout          (sout),
        .clk_div_word  (clk_div_word),
        .clk_div_frame (clk_div_frame)
    );

    // {mode, word, serial nibble}
    localparam logic [8:0] VEC [0:5] = '{
        9'h0A0, 9'h01F, 9'h0E3, 9'h13C, 9'h10F, 9'h1F5
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [3:0] w, input logic [3:0] s, input int k);
        return (k < 4) ? w[k] : s[k-4];
    endfunction

    // Called at negedge+1; releases sync before the next rising edge.
    task automatic sync_pulse(input logic [3:0] w);
        @(negedge clk); #1 sync = 1'b1;
        @(negedge clk); #1 sync = 1'b0;
        din = w;
    endtask

    // Runs one frame starting at negedge+1 before its load edge.
    task automatic run_frame(input logic m, input logic [3:0] w, input logic [3:0] s,
                             input logic [3:0] nxt, input string req);
        int f;
        f = m ? 8 : 4;
        for (int k = 0; k < f; k++) begin
            ser_in = (m && k >= 4) ? s[k-4] : ~w[k % 4];   // R7 unused serial slots
            @(posedge clk); #1;
            if (k > 0) chk("R8 sout stable over rising edge", sout, exp_bit(w, s, k-1));
            @(negedge clk); #1;
            chk(req, sout, exp_bit(w, s, k));
            din = (k == f - 1) ? nxt : ~w;                 // R7 din outside load
        end
    endtask

    initial begin
        logic [3:0] w, s;
        logic       m;
        logic       held;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        chk("R9 reset sout", sout, 0);
        chk("R9 reset div word", clk_div_word, 0);
        chk("R9 reset div frame", clk_div_frame, 0);

        // Vector table walk: R1 single mode, R3 cascade mode, R5 first load, R7.
        for (int i = 0; i < 6; i++) begin
            m = VEC[i][8];
            w = VEC[i][7:4];
            s = VEC[i][3:0];
            mode = m;
            sync_pulse(w);
            run_frame(m, w, s, w, m ? "R3 cascade frame bit" : "R1 single bit order");
        end

        // R4 divided clocks after release.
        sync_pulse(4'h0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); #1;
            chk("R4 div word", clk_div_word, ((k + 1) / 2) % 2);
            chk("R4 div frame", clk_div_frame, ((k + 1) / 4) % 2);
        end

        // R2 back-to-back words in single mode.
        mode = 1'b0;
        sync_pulse(4'h6);
        run_frame(1'b0, 4'h6, 4'h0, 4'h9, "R2 first word");
        run_frame(1'b0, 4'h9, 4'h0, 4'h5, "R2 second word");
        run_frame(1'b0, 4'h5, 4'h0, 4'h5, "R2 third word");

        // R3 back-to-back cascade frames: next load after eight clocks.
        mode = 1'b1;
        sync_pulse(4'h2);
        run_frame(1'b1, 4'h2, 4'h9, 4'hC, "R3 cascade first frame");
        run_frame(1'b1, 4'hC, 4'h6, 4'hC, "R3 cascade second frame");

        // R5/R6 sync asserted mid-frame, then restart.
        mode = 1'b0;
        sync_pulse(4'hB);
        @(negedge clk); #1;
        @(negedge clk); #1;
        held = sout;
        chk("R1 bit before sync", sout, 1);   // 0xB bit1 = 1
        sync = 1'b1;
        din = 4'h4;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            chk("R6 sout held in sync", sout, held);
            chk("R5 div word low in sync", clk_div_word, 0);
            chk("R5 div frame low in sync", clk_div_frame, 0);
        end
        sync = 1'b0;
        @(negedge clk); #1;
        chk("R5 first bit after release", sout, 0);   // 0x4 bit0
        din = 4'hF;
        @(negedge clk); #1;
        chk("R7 word kept after din change", sout, 0); // 0x4 bit1
        @(negedge clk); #1;
        chk("R7 word kept after din change", sout, 1); // 0x4 bit2

        // R9 reset mid-stream.
        rst = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk("R9 reset sout", sout, 0);
        chk("R9 reset div word", clk_div_word, 0);
        chk("R9 reset div frame", clk_div_frame, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule